// File: doc/BRIEF.md
# Overcurrent Guard with Softstart Retry

This block protects a bank of power output drivers. For each channel it receives a raw overcurrent comparator and a raw open-load comparator. It also receives one warning-level and one shutdown-level temperature comparator that are shared by the whole bank. Each raw input passes through a persistence filter that counts ticks of a slow time base, so a flag latches only after the condition has held long enough. The default counts are 64 ticks for overcurrent and temperature and 2000 ticks for open load. These match 32 µs and 1 ms at a 2 MHz tick.

A confirmed overcurrent switches its driver off. When the channel's recovery bit is clear, the driver stays off until the host pulses the clear input. When the recovery bit is set, a per-channel pacer switches the driver back on by itself. The pacer runs a retry cycle of eight slots, each `RETRY_UNIT` ticks long. The driver is off for the first slots of each cycle and on for the last one slot (about 12 %) or the last two slots (25 %). This lets lamps and motors with large inrush currents come up to speed. A confirmed thermal shutdown forces every driver off until the host clears it. Open-load and temperature-warning flags only report and never change a driver's state.

Top module: `ocp_guard`

## Requirements
- R1: The overcurrent flag of a channel sets on the `OC_TICKS`-th consecutive tick at which `oc_raw` is high and that channel's driver is enabled, and not before.
- R2: A single cycle with the filter condition low restarts that filter's count from zero, so a full run of ticks is needed again.
- R3: With the overcurrent flag set and the recovery bit clear, `drv_en` of that channel stays low, and the flag stays set until `clr` is pulsed.
- R4: With the overcurrent flag and the recovery bit both set, the retry phase advances by one on every tick, starting at 0 on the tick after the flag latched and wrapping after 8·`RETRY_UNIT` ticks. The driver is enabled while the phase is at or above (8−n)·`RETRY_UNIT`, where n=1 for `duty_sel`=0 and n=2 for `duty_sel`=1.
- R5: The open-load flag sets after `OL_TICKS` consecutive ticks of `ol_raw` high while that driver is enabled. While the driver is disabled, `ol_raw` has no effect.
- R6: Open-load and temperature-warning flags never change `drv_en`.
- R7: The thermal-shutdown flag sets after `OT_TICKS` consecutive ticks of `tsd_raw` high. While it is set, all `drv_en` bits are low, and it stays set until `clr`.
- R8: A `clr` pulse clears every flag at the next clock edge and restarts every filter count. `clr` takes priority over a condition that is still present.
- R9: While `rst_n` is low at a clock edge, all flags clear and `drv_en` equals `drv_req`.
- R10: A driver is never enabled while its `drv_req` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Filter and retry time-base strobe |
| drv_req | input | NCH | Host request to turn each driver on |
| rcv_en | input | NCH | Per-channel automatic retry enable |
| duty_sel | input | 1 | Retry on-duty: 0 = one slot of 8, 1 = two slots of 8 |
| clr | input | 1 | Host pulse that clears all flags |
| oc_raw | input | NCH | Raw overcurrent comparators |
| ol_raw | input | NCH | Raw open-load comparators |
| tw_raw | input | 1 | Raw temperature-warning comparator |
| tsd_raw | input | 1 | Raw thermal-shutdown comparator |
| drv_en | output | NCH | Gated driver enables |
| oc_flag | output | NCH | Latched overcurrent flags |
| ol_flag | output | NCH | Latched open-load flags |
| tw_flag | output | 1 | Latched temperature-warning flag |
| tsd_flag | output | 1 | Latched thermal-shutdown flag |

## Verification
The overcurrent filter is driven with steady runs and with runs broken by a one-cycle gap at every possible position. This separates a counter that restarts from one that only pauses or keeps counting. The retry pacer is swept through three full periods at both duty settings, and every cycle is compared with the slot arithmetic. This exposes off-by-one errors in the phase origin, the wrap point and the on-window. Open-load stimulus is applied both with the driver off and with it on, to show that the activation gating works. Thermal and clear pulses are placed in the middle of a count, to tell global shutdown, clear priority and counter re-arming apart.

// File: rtl/ocg_pkg.sv
// Shared types for the overcurrent guard.
// Assumes: the retry cycle is always eight slots long.
package ocg_pkg;
    localparam int RETRY_SLOTS = 8;

    typedef enum logic {
        DUTY_ONE_SLOT = 1'b0,
        DUTY_TWO_SLOT = 1'b1
    } duty_t;

    // Number of enabled slots per retry cycle for a duty setting.
    function automatic int on_slots(input duty_t d);
        return (d == DUTY_TWO_SLOT) ? 2 : 1;
    endfunction
endpackage

// File: rtl/persist_filter.sv
// Persistence filter: latches a flag once its condition has been high on
// LIMIT consecutive ticks. Any cycle with the condition low restarts the count.
// Assumes: clr has priority over the condition; LIMIT >= 1.
module persist_filter #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    input  logic clr,
    output logic flag
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count consecutive ticks of the condition and latch the flag at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (tick && !flag) begin
            if (cnt == CW'(LIMIT - 1)) begin
                cnt  <= '0;
                flag <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R1
    set_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cond));

    // R8
    clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);

    // R3
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
endmodule

// File: rtl/retry_pacer.sv
// Softstart retry pacer: while armed, it steps a phase through
// RETRY_SLOTS*UNIT ticks and opens an on-window in the last one or two slots.
// Assumes: arm is low whenever retry is not wanted; the phase restarts at 0.
module retry_pacer
    import ocg_pkg::*;
#(
    parameter int UNIT = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  arm,
    input  duty_t duty_sel,
    output logic  on_win
);
    localparam int PERIOD = RETRY_SLOTS * UNIT;
    localparam int PW     = $clog2(PERIOD);

    logic [PW-1:0] phase;
    int            off_len;

    // Advance the retry phase on each tick while armed, wrapping at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == PW'(PERIOD - 1)) ? '0 : phase + 1'b1;
        end
    end

    // Open the on-window in the trailing slots of the cycle.
    always_comb begin
        off_len = (RETRY_SLOTS - on_slots(duty_sel)) * UNIT;
        on_win  = arm && (int'(phase) >= off_len);
    end

    // R4
    phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> phase == '0);
endmodule

// File: rtl/ocp_guard.sv
// Per-channel protection controller for a bank of output drivers.
// It filters the overcurrent, open-load and temperature comparators, latches
// the flags and gates the driver enables. A confirmed overload either
// latches the driver off or hands it to a softstart retry pacer.
// Assumes: tick is a one-cycle strobe of the filter time base; clr is a pulse.
module ocp_guard
    import ocg_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int OC_TICKS   = 64,
    parameter int OL_TICKS   = 2000,
    parameter int OT_TICKS   = 64,
    parameter int RETRY_UNIT = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [NCH-1:0] drv_req,
    input  logic [NCH-1:0] rcv_en,
    input  logic           duty_sel,
    input  logic           clr,
    input  logic [NCH-1:0] oc_raw,
    input  logic [NCH-1:0] ol_raw,
    input  logic           tw_raw,
    input  logic           tsd_raw,
    output logic [NCH-1:0] drv_en,
    output logic [NCH-1:0] oc_flag,
    output logic [NCH-1:0] ol_flag,
    output logic           tw_flag,
    output logic           tsd_flag
);
    duty_t duty;
    assign duty = duty_t'(duty_sel);

    persist_filter #(.LIMIT(OT_TICKS)) u_tw (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cond(tw_raw), .clr(clr), .flag(tw_flag)
    );

    persist_filter #(.LIMIT(OT_TICKS)) u_tsd (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cond(tsd_raw), .clr(clr), .flag(tsd_flag)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic on_win;
        logic oc_cond;
        logic ol_cond;

        // Both current checks only make sense on an activated output.
        assign oc_cond = oc_raw[i] && drv_en[i];
        assign ol_cond = ol_raw[i] && drv_en[i];

        persist_filter #(.LIMIT(OC_TICKS)) u_oc (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .cond(oc_cond), .clr(clr), .flag(oc_flag[i])
        );

        persist_filter #(.LIMIT(OL_TICKS)) u_ol (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .cond(ol_cond), .clr(clr), .flag(ol_flag[i])
        );

        retry_pacer #(.UNIT(RETRY_UNIT)) u_retry (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .arm(oc_flag[i] && rcv_en[i]), .duty_sel(duty), .on_win(on_win)
        );

        // Gate the request by thermal shutdown and by the overload state.
        always_comb begin
            drv_en[i] = drv_req[i] && !tsd_flag && (!oc_flag[i] || on_win);
        end

        // R3
        latched_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            oc_flag[i] && !rcv_en[i] |-> !drv_en[i]);

        // R7
        thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tsd_flag |-> !drv_en[i]);
    end
endmodule

// File: tb/ocp_guard_tb_top.sv
module ocp_guard_tb_top;
    localparam int NCH = 2;
    localparam int OC  = 4;
    localparam int OL  = 6;
    localparam int OT  = 3;
    localparam int U   = 2;
    localparam int PER = 8 * U;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b1;
    logic [NCH-1:0] drv_req = '0;
    logic [NCH-1:0] rcv_en = '0;
    logic           duty_sel = 1'b0;
    logic           clr = 1'b0;
    logic [NCH-1:0] oc_raw = '0;
    logic [NCH-1:0] ol_raw = '0;
    logic           tw_raw = 1'b0;
    logic           tsd_raw = 1'b0;
    logic [NCH-1:0] drv_en, oc_flag, ol_flag;
    logic           tw_flag, tsd_flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ocp_guard #(.NCH(NCH), .OC_TICKS(OC), .OL_TICKS(OL), .OT_TICKS(OT),
                .RETRY_UNIT(U)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .drv_req(drv_req),
        .rcv_en(rcv_en), .duty_sel(duty_sel), .clr(clr), .oc_raw(oc_raw),
        .ol_raw(ol_raw), .tw_raw(tw_raw), .tsd_raw(tsd_raw), .drv_en(drv_en),
        .oc_flag(oc_flag), .ol_flag(ol_flag), .tw_flag(tw_flag),
        .tsd_flag(tsd_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        drv_req = 2'b11;
        cyc(2);
        // R9 reset state
        chk("R9 drv_en", 32'(drv_en), 32'b11);
        chk("R9 flags", 32'({oc_flag, ol_flag, tw_flag, tsd_flag}), 32'd0);
        rst_n = 1'b1;
        cyc(1);

        // R1 filter length
        oc_raw[0] = 1'b1;
        cyc(OC - 1);
        chk("R1 early", 32'(oc_flag), 32'b00);
        cyc(1);
        chk("R1 set", 32'(oc_flag), 32'b01);
        chk("R3 off", 32'(drv_en), 32'b10);

        // R3 latched off without recovery
        for (int k = 0; k < 20; k++) begin
            cyc(1);
            chk("R3 hold", 32'({oc_flag[0], drv_en[0]}), 32'b10);
        end
        oc_raw[0] = 1'b0;
        pulse_clr();
        chk("R8 clear", 32'(oc_flag), 32'b00);
        chk("R3 re-enable", 32'(drv_en), 32'b11);

        // R2 gap at every position restarts the count
        for (int g = 1; g < OC; g++) begin
            oc_raw[0] = 1'b1;
            cyc(g);
            oc_raw[0] = 1'b0;
            cyc(1);
            oc_raw[0] = 1'b1;
            cyc(OC - 1);
            chk("R2 restart", 32'(oc_flag), 32'b00);
            cyc(1);
            chk("R2 after full run", 32'(oc_flag), 32'b01);
            oc_raw[0] = 1'b0;
            pulse_clr();
        end

        // R4 retry pattern at both duty settings
        for (int ds = 0; ds < 2; ds++) begin
            duty_sel = ds[0];
            rcv_en[0] = 1'b1;
            oc_raw[0] = 1'b1;
            cyc(OC);
            chk("R4 flag", 32'(oc_flag[0]), 32'd1);
            for (int k = 0; k < 3 * PER; k++) begin
                int n;
                n = (ds == 1) ? 2 : 1;
                chk("R4 duty", 32'(drv_en[0]), 32'((k % PER) >= (8 - n) * U));
                chk("R4 other ch", 32'(drv_en[1]), 32'd1);
                cyc(1);
            end
            rcv_en[0] = 1'b0;
            #1;
            chk("R3 retry off", 32'(drv_en[0]), 32'd0);
            oc_raw[0] = 1'b0;
            pulse_clr();
            chk("R8 clear retry", 32'({oc_flag[0], drv_en[0]}), 32'b01);
        end

        // R5 open load ignored on a disabled output
        drv_req = 2'b01;
        ol_raw[1] = 1'b1;
        cyc(3 * OL);
        chk("R5 ignored", 32'(ol_flag), 32'b00);
        drv_req = 2'b11;
        cyc(OL - 1);
        chk("R5 early", 32'(ol_flag), 32'b00);
        cyc(1);
        chk("R5 set", 32'(ol_flag), 32'b10);
        chk("R6 ol no gate", 32'(drv_en), 32'b11);
        tw_raw = 1'b1;
        cyc(OT);
        chk("R6 tw set", 32'(tw_flag), 32'd1);
        chk("R6 tw no gate", 32'(drv_en), 32'b11);

        // R7 thermal shutdown
        tsd_raw = 1'b1;
        cyc(OT - 1);
        chk("R7 early", 32'({tsd_flag, drv_en}), 32'b011);
        cyc(1);
        chk("R7 all off", 32'({tsd_flag, drv_en}), 32'b100);
        tsd_raw = 1'b0;
        ol_raw[1] = 1'b0;
        tw_raw = 1'b0;
        cyc(5);
        chk("R7 stays off", 32'({tsd_flag, drv_en}), 32'b100);
        pulse_clr();
        chk("R8 all flags", 32'({oc_flag, ol_flag, tw_flag, tsd_flag}), 32'd0);
        chk("R7 released", 32'(drv_en), 32'b11);

        // R10 request gating
        drv_req = 2'b01;
        #1;
        chk("R10 partial", 32'(drv_en), 32'b01);
        drv_req = 2'b00;
        #1;
        chk("R10 none", 32'(drv_en), 32'b00);
        drv_req = 2'b11;

        // R8 clear in the middle of a count re-arms the filter
        oc_raw[1] = 1'b1;
        cyc(OC - 2);
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
        cyc(OC - 1);
        chk("R8 rearm early", 32'(oc_flag), 32'b00);
        cyc(1);
        chk("R8 rearm set", 32'(oc_flag), 32'b10);
        oc_raw[1] = 1'b0;
        pulse_clr();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule